// File: doc/BRIEF.md
# UART Host Register Bank Decoder

This block is the processor-facing register file of a single UART channel. A host reaches eight offsets through a 3-bit address, one read strobe, one write strobe and byte-wide data buses. The block decodes each access into a target register, keeps the writable control registers, and returns the status bytes supplied by the receive path, interrupt logic, line monitor and modem monitor. It does not shift serial data, generate baud ticks or drive modem pins. It only exposes their controls and samples their status.

Two features set the map apart. Offset 2 reads the interrupt status but writes the FIFO control register, which is write-only. Bit 7 of line control selects a second bank, in which offsets 0 and 1 become the low and high bytes of a 16-bit baud divisor. Line control stays at offset 3 in both banks, so the host can always return to the normal bank. The block also turns some accesses into single-cycle side-effect pulses. Host data for the transmit FIFO produces a push, a host read of received data produces a pop, and a FIFO control write produces a strobe.

Top module: `uart_regbank`

## Requirements
- R1: After reset, int_en, fifo_ctl, line_ctl, modem_ctl, the scratch byte and rdata are 0x00, divisor is 0x0000, and tx_push, rx_pop and fcr_wr are 0.
- R2: With line_ctl[7]=0, a read strobe at offset 0 returns rx_data, at offset 2 returns int_status, at offset 5 returns line_status and at offset 6 returns modem_status. The byte appears on rdata in the cycle after the strobe and holds until the next read.
- R3: With line_ctl[7]=0, the interrupt-enable register (offset 1) and the modem-control register (offset 4) read back the last byte written. The same bytes drive int_en and modem_ctl.
- R4: With line_ctl[7]=0, a write at offset 2 stores the byte in fifo_ctl and raises fcr_wr for exactly one cycle after the strobe. fifo_en equals fifo_ctl bit 0.
- R5: Writes at offsets 5 and 6 change no register and produce no pulse. Later reads still return the live status inputs.
- R6: With line_ctl[7]=0, a write at offset 0 raises tx_push for one cycle, with tx_data equal to the written byte. A read at offset 0 raises rx_pop for one cycle.
- R7: With line_ctl[7]=1, offset 0 is divisor[7:0] and offset 1 is divisor[15:8]. Both are readable and writable, and accesses to them raise neither tx_push nor rx_pop.
- R8: Line control sits at offset 3 in both banks and reads back what was written. Writing bit 7 as 0 returns to the normal bank.
- R9: With line_ctl[7]=1, offsets 2, 4, 5, 6 and 7 read 0x00 and ignore writes. fcr_wr does not pulse.
- R10: The scratch byte at offset 7 (normal bank) reads back the last byte written and causes no pulse and no change to any other register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register offset |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| wr_stb | input | 1 | Write strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rx_data | input | 8 | Head byte of the receive FIFO |
| int_status | input | 8 | Interrupt status byte |
| line_status | input | 8 | Line status byte |
| modem_status | input | 8 | Modem status byte |
| tx_push | output | 1 | Push pulse to the transmit FIFO |
| tx_data | output | 8 | Byte to push |
| rx_pop | output | 1 | Pop pulse to the receive FIFO |
| fcr_wr | output | 1 | FIFO control write pulse |
| fifo_ctl | output | 8 | FIFO control register |
| fifo_en | output | 1 | FIFO enable (fifo_ctl bit 0) |
| int_en | output | 8 | Interrupt enable register |
| line_ctl | output | 8 | Line control register |
| modem_ctl | output | 8 | Modem control register |
| divisor | output | 16 | Baud divisor latch |

## Verification
A wrong bank bit or a wrong decode shows up in the cycle after the next read strobe, as rdata returning the divisor instead of host data or the reverse, or a stale byte in place of 0x00. A corrupted control register shows at once on its output port and again on read-back. Misrouted side effects appear as a missing or extra pulse one cycle after the strobe. The bench therefore samples pulses in exactly that cycle and checks that they have dropped in the cycle after.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;
   localparam int NREG = 10;
   // register slot indices
   localparam int IX_HOLD = 0;
   localparam int IX_IER  = 1;
   localparam int IX_ISRF = 2;
   localparam int IX_LCR  = 3;
   localparam int IX_MCR  = 4;
   localparam int IX_LSR  = 5;
   localparam int IX_MSR  = 6;
   localparam int IX_SPR  = 7;
   localparam int IX_DLL  = 8;
   localparam int IX_DLM  = 9;
   // offsets the behaviour depends on
   localparam logic [2:0] OFS_HOLD = 3'd0;
   localparam logic [2:0] OFS_IER  = 3'd1;
   localparam logic [2:0] OFS_ISRF = 3'd2;
   localparam logic [2:0] OFS_LCR  = 3'd3;
   localparam logic [2:0] OFS_MCR  = 3'd4;
   localparam logic [2:0] OFS_LSR  = 3'd5;
   localparam logic [2:0] OFS_MSR  = 3'd6;
   localparam logic [2:0] OFS_SPR  = 3'd7;
   localparam int BANK_BIT = 7;
   typedef logic [NREG-1:0] reg_sel_t;
endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
   import uart_regbank_pkg::*;
#(
   parameter int AW            = 3,
   parameter bit DIV_BANK_PASS = 1'b0
) (
   input  logic [AW-1:0] addr,
   input  logic          div_bank,
   output reg_sel_t      sel
);
   logic others_ok;

   generate
      if (DIV_BANK_PASS) begin : g_pass
         assign others_ok = 1'b1;
      end else begin : g_block
         assign others_ok = ~div_bank;
      end
   endgenerate

   always_comb begin
      sel = '0;
      unique case (addr)
         OFS_HOLD: if (div_bank) sel[IX_DLL] = 1'b1; else sel[IX_HOLD] = 1'b1;
         OFS_IER:  if (div_bank) sel[IX_DLM] = 1'b1; else sel[IX_IER]  = 1'b1;
         OFS_LCR:  sel[IX_LCR] = 1'b1;
         OFS_ISRF: sel[IX_ISRF] = others_ok;
         OFS_MCR:  sel[IX_MCR]  = others_ok;
         OFS_LSR:  sel[IX_LSR]  = others_ok;
         OFS_MSR:  sel[IX_MSR]  = others_ok;
         OFS_SPR:  sel[IX_SPR]  = others_ok;
         default:  sel = '0;
      endcase
   end
endmodule

// File: rtl/uart_rb_store.sv
module uart_rb_store
   import uart_regbank_pkg::*;
#(
   parameter int          DW      = 8,
   parameter logic [15:0] DIV_RST = 16'h0000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_stb,
   input  logic [DW-1:0] wdata,
   input  reg_sel_t      sel,
   output logic [DW-1:0] ier_q,
   output logic [DW-1:0] fcr_q,
   output logic [DW-1:0] lcr_q,
   output logic [DW-1:0] mcr_q,
   output logic [DW-1:0] spr_q,
   output logic [DW-1:0] dll_q,
   output logic [DW-1:0] dlm_q,
   output logic          fcr_wr_q,
   output logic          push_q,
   output logic [DW-1:0] push_data_q
);
   localparam logic [DW-1:0] ZERO = '0;
   reg_sel_t we;
   assign we = wr_stb ? sel : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ier_q       <= ZERO;
         fcr_q       <= ZERO;
         lcr_q       <= ZERO;
         mcr_q       <= ZERO;
         spr_q       <= ZERO;
         dll_q       <= DIV_RST[DW-1:0];
         dlm_q       <= DIV_RST[2*DW-1:DW];
         push_data_q <= ZERO;
      end else begin
         if (we[IX_IER])  ier_q       <= wdata;
         if (we[IX_ISRF]) fcr_q       <= wdata;
         if (we[IX_LCR])  lcr_q       <= wdata;
         if (we[IX_MCR])  mcr_q       <= wdata;
         if (we[IX_SPR])  spr_q       <= wdata;
         if (we[IX_DLL])  dll_q       <= wdata;
         if (we[IX_DLM])  dlm_q       <= wdata;
         if (we[IX_HOLD]) push_data_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fcr_wr_q <= 1'b0;
         push_q   <= 1'b0;
      end else begin
         fcr_wr_q <= we[IX_ISRF];
         push_q   <= we[IX_HOLD];
      end
   end
endmodule

// File: rtl/uart_rb_rdmux.sv
module uart_rb_rdmux
   import uart_regbank_pkg::*;
#(
   parameter int DW = 8
) (
   input  reg_sel_t      sel,
   input  logic [DW-1:0] src [NREG],
   output logic [DW-1:0] rd
);
   logic [DW-1:0] gated [NREG];

   generate
      for (genvar i = 0; i < NREG; i++) begin : g_gate
         assign gated[i] = src[i] & {DW{sel[i]}};
      end
   endgenerate

   always_comb begin
      rd = '0;
      for (int i = 0; i < NREG; i++) rd = rd | gated[i];
   end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
   import uart_regbank_pkg::*;
#(
   parameter int          AW            = 3,
   parameter int          DW            = 8,
   parameter bit          DIV_BANK_PASS = 1'b0,
   parameter logic [15:0] DIV_RST       = 16'h0000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    addr,
   input  logic          rd_stb,
   input  logic          wr_stb,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata,
   input  logic [7:0]    rx_data,
   input  logic [7:0]    int_status,
   input  logic [7:0]    line_status,
   input  logic [7:0]    modem_status,
   output logic          tx_push,
   output logic [7:0]    tx_data,
   output logic          rx_pop,
   output logic          fcr_wr,
   output logic [7:0]    fifo_ctl,
   output logic          fifo_en,
   output logic [7:0]    int_en,
   output logic [7:0]    line_ctl,
   output logic [7:0]    modem_ctl,
   output logic [15:0]   divisor
);
   generate
      if (AW != 3 || DW != 8) begin : g_bad_cfg
         $error("uart_regbank: AW must be 3 and DW must be 8");
      end
   endgenerate

   reg_sel_t      sel;
   logic [DW-1:0] ier_q, fcr_q, lcr_q, mcr_q, spr_q, dll_q, dlm_q, push_data_q;
   logic          fcr_wr_q, push_q;
   logic [DW-1:0] src [NREG];
   logic [DW-1:0] rd_mux;
   logic          pop_q;

   uart_rb_decode #(.AW(AW), .DIV_BANK_PASS(DIV_BANK_PASS)) u_dec (
      .addr     (addr),
      .div_bank (lcr_q[BANK_BIT]),
      .sel      (sel)
   );

   uart_rb_store #(.DW(DW), .DIV_RST(DIV_RST)) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_stb      (wr_stb),
      .wdata       (wdata),
      .sel         (sel),
      .ier_q       (ier_q),
      .fcr_q       (fcr_q),
      .lcr_q       (lcr_q),
      .mcr_q       (mcr_q),
      .spr_q       (spr_q),
      .dll_q       (dll_q),
      .dlm_q       (dlm_q),
      .fcr_wr_q    (fcr_wr_q),
      .push_q      (push_q),
      .push_data_q (push_data_q)
   );

   assign src[IX_HOLD] = rx_data;
   assign src[IX_IER]  = ier_q;
   assign src[IX_ISRF] = int_status;
   assign src[IX_LCR]  = lcr_q;
   assign src[IX_MCR]  = mcr_q;
   assign src[IX_LSR]  = line_status;
   assign src[IX_MSR]  = modem_status;
   assign src[IX_SPR]  = spr_q;
   assign src[IX_DLL]  = dll_q;
   assign src[IX_DLM]  = dlm_q;

   uart_rb_rdmux #(.DW(DW)) u_mux (
      .sel (sel),
      .src (src),
      .rd  (rd_mux)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
         pop_q <= 1'b0;
      end else begin
         if (rd_stb) rdata <= rd_mux;
         pop_q <= rd_stb & sel[IX_HOLD];
      end
   end

   assign tx_push   = push_q;
   assign tx_data   = push_data_q;
   assign rx_pop    = pop_q;
   assign fcr_wr    = fcr_wr_q;
   assign fifo_ctl  = fcr_q;
   assign fifo_en   = fcr_q[0];
   assign int_en    = ier_q;
   assign line_ctl  = lcr_q;
   assign modem_ctl = mcr_q;
   assign divisor   = {dlm_q, dll_q};
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [2:0]  addr,
   input logic        rd_stb,
   input logic        wr_stb,
   input logic [7:0]  wdata,
   input logic [7:0]  rdata,
   input logic [7:0]  line_status,
   input logic        tx_push,
   input logic [7:0]  tx_data,
   input logic        rx_pop,
   input logic        fcr_wr,
   input logic [7:0]  fifo_ctl,
   input logic [7:0]  int_en,
   input logic [7:0]  line_ctl,
   input logic [7:0]  modem_ctl,
   input logic [15:0] divisor
);
   assert_push_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_push |-> $past(wr_stb && addr == 3'd0 && !line_ctl[7]) && tx_data == $past(wdata));

   assert_pop_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_pop |-> $past(rd_stb && addr == 3'd0 && !line_ctl[7]));

   assert_fcr_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fcr_wr |-> fifo_ctl == $past(wdata) && $past(wr_stb && addr == 3'd2 && !line_ctl[7]));

   assert_ro_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && (addr == 3'd5 || addr == 3'd6))
      |=> $stable({int_en, line_ctl, modem_ctl, fifo_ctl, divisor}) && !tx_push && !fcr_wr);

   assert_lcr_both_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && addr == 3'd3) |=> line_ctl == $past(wdata));

   assert_lsr_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && addr == 3'd5 && !line_ctl[7]) |=> rdata == $past(line_status));

   assert_div_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_stb && line_ctl[7] && addr <= 3'd1) |=> $stable(divisor));
endmodule

bind uart_regbank uart_regbank_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .addr         (addr),
   .rd_stb       (rd_stb),
   .wr_stb       (wr_stb),
   .wdata        (wdata),
   .rdata        (rdata),
   .line_status  (line_status),
   .tx_push      (tx_push),
   .tx_data      (tx_data),
   .rx_pop       (rx_pop),
   .fcr_wr       (fcr_wr),
   .fifo_ctl     (fifo_ctl),
   .int_en       (int_en),
   .line_ctl     (line_ctl),
   .modem_ctl    (modem_ctl),
   .divisor      (divisor)
);

// File: tb/uart_regbank_tb.sv
module uart_regbank_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  addr = '0;
   logic        rd_stb = 1'b0, wr_stb = 1'b0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic [7:0]  rx_data = 8'hA5, int_status = 8'hC1, line_status = 8'h60, modem_status = 8'hB0;
   logic        tx_push, rx_pop, fcr_wr, fifo_en;
   logic [7:0]  tx_data, fifo_ctl, int_en, line_ctl, modem_ctl;
   logic [15:0] divisor;
   int checks = 0, errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   uart_regbank u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
      .wdata(wdata), .rdata(rdata), .rx_data(rx_data), .int_status(int_status),
      .line_status(line_status), .modem_status(modem_status), .tx_push(tx_push),
      .tx_data(tx_data), .rx_pop(rx_pop), .fcr_wr(fcr_wr), .fifo_ctl(fifo_ctl),
      .fifo_en(fifo_en), .int_en(int_en), .line_ctl(line_ctl), .modem_ctl(modem_ctl),
      .divisor(divisor)
   );

   // vector: {req[3:0], wr, addr[2:0], byte[7:0]}; for reads byte is the expected rdata
   localparam int NV = 39;
   localparam logic [15:0] VEC [NV] = '{
      {4'd2, 1'b0, 3'd0, 8'hA5},
      {4'd3, 1'b1, 3'd1, 8'h0F}, {4'd3, 1'b0, 3'd1, 8'h0F},
      {4'd2, 1'b0, 3'd2, 8'hC1},
      {4'd3, 1'b1, 3'd4, 8'h1B}, {4'd3, 1'b0, 3'd4, 8'h1B},
      {4'd10, 1'b1, 3'd7, 8'h5A}, {4'd10, 1'b0, 3'd7, 8'h5A},
      {4'd5, 1'b0, 3'd5, 8'h60}, {4'd5, 1'b1, 3'd5, 8'hFF}, {4'd5, 1'b0, 3'd5, 8'h60},
      {4'd5, 1'b0, 3'd6, 8'hB0}, {4'd5, 1'b1, 3'd6, 8'hFF}, {4'd5, 1'b0, 3'd6, 8'hB0},
      {4'd5, 1'b0, 3'd1, 8'h0F}, {4'd5, 1'b0, 3'd4, 8'h1B},
      {4'd8, 1'b1, 3'd3, 8'h03}, {4'd8, 1'b0, 3'd3, 8'h03},
      {4'd8, 1'b1, 3'd3, 8'h83}, {4'd8, 1'b0, 3'd3, 8'h83},
      {4'd7, 1'b0, 3'd0, 8'h00}, {4'd7, 1'b1, 3'd0, 8'h34}, {4'd7, 1'b0, 3'd0, 8'h34},
      {4'd7, 1'b1, 3'd1, 8'h12}, {4'd7, 1'b0, 3'd1, 8'h12}, {4'd7, 1'b0, 3'd0, 8'h34},
      {4'd9, 1'b0, 3'd2, 8'h00}, {4'd9, 1'b0, 3'd4, 8'h00}, {4'd9, 1'b0, 3'd5, 8'h00},
      {4'd9, 1'b0, 3'd6, 8'h00}, {4'd9, 1'b0, 3'd7, 8'h00},
      {4'd9, 1'b1, 3'd7, 8'hEE}, {4'd9, 1'b1, 3'd4, 8'hFF}, {4'd9, 1'b1, 3'd2, 8'hFF},
      {4'd8, 1'b1, 3'd3, 8'h03},
      {4'd9, 1'b0, 3'd7, 8'h5A}, {4'd9, 1'b0, 3'd4, 8'h1B}, {4'd9, 1'b0, 3'd1, 8'h0F},
      {4'd9, 1'b0, 3'd2, 8'hC1}
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // one access; returns at the negedge after the strobe edge, when results are visible
   task automatic acc(input logic wr, input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_stb = wr; rd_stb = ~wr;
      @(negedge clk);
      wr_stb = 1'b0; rd_stb = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 regs", {int_en, fifo_ctl}, 16'h0000);
      chk("R1 lcr/mcr", {line_ctl, modem_ctl}, 16'h0000);
      chk("R1 divisor", divisor, 16'h0000);
      chk("R1 pulses", {13'd0, tx_push, rx_pop, fcr_wr}, 16'h0000);
      chk("R1 rdata", {8'h00, rdata}, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         logic [15:0] v;
         v = VEC[i];
         acc(v[11], v[10:8], v[7:0]);
         if (!v[11]) chk($sformatf("R%0d vec %0d", v[15:12], i), {8'h00, rdata}, {8'h00, v[7:0]});
      end
      chk("R7 divisor port", divisor, 16'h1234);
      chk("R9 fifo_ctl untouched", {8'h00, fifo_ctl}, 16'h0000);
      chk("R8 line_ctl port", {8'h00, line_ctl}, 16'h0003);
      chk("R3 ports", {int_en, modem_ctl}, 16'h0F1B);

      // R6 push
      acc(1'b1, 3'd0, 8'hC3);
      chk("R6 push", {7'd0, tx_push, tx_data}, 16'h01C3);
      @(negedge clk);
      chk("R6 push drop", {15'd0, tx_push}, 16'h0000);
      // R6 pop
      acc(1'b0, 3'd0, 8'h00);
      chk("R6 pop", {15'd0, rx_pop}, 16'h0001);
      @(negedge clk);
      chk("R6 pop drop", {15'd0, rx_pop}, 16'h0000);
      // R10 scratch side effects
      acc(1'b1, 3'd7, 8'h99);
      chk("R10 no pulse", {13'd0, tx_push, rx_pop, fcr_wr}, 16'h0000);
      chk("R10 others", {int_en, modem_ctl}, 16'h0F1B);
      // R4 fifo control
      acc(1'b1, 3'd2, 8'h07);
      chk("R4 fcr pulse", {7'd0, fcr_wr, fifo_ctl}, 16'h0107);
      chk("R4 fifo_en", {15'd0, fifo_en}, 16'h0001);
      @(negedge clk);
      chk("R4 pulse drop", {15'd0, fcr_wr}, 16'h0000);
      acc(1'b1, 3'd2, 8'h06);
      chk("R4 fifo_en off", {15'd0, fifo_en}, 16'h0000);
      // R7 no push/pop in divisor bank
      acc(1'b1, 3'd3, 8'h80);
      acc(1'b1, 3'd0, 8'h55);
      chk("R7 no push", {15'd0, tx_push}, 16'h0000);
      chk("R7 dll write", divisor, 16'h1255);
      acc(1'b0, 3'd0, 8'h00);
      chk("R7 no pop", {7'd0, rx_pop, rdata}, 16'h0055);
      acc(1'b1, 3'd2, 8'hFF);
      chk("R9 no fcr pulse", {7'd0, fcr_wr, fifo_ctl}, 16'h0006);

      // R1 reset again
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 re-reset regs", {line_ctl, fifo_ctl}, 16'h0000);
      chk("R1 re-reset divisor", divisor, 16'h0000);
      chk("R1 re-reset rdata", {int_en, rdata}, 16'h0000);
      rst_n = 1'b1;
      acc(1'b0, 3'd7, 8'h00);
      chk("R1 scratch reset", {8'h00, rdata}, 16'h0000);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule